// File: doc/BRIEF.md
# Switch Bounce Edge Counter

This block makes the bouncing of a mechanical switch visible. The raw switch level, which is asynchronous to the system clock, is captured into a two-stage shift register. Each sampling instant moves the newest sample into the older stage and loads a fresh one. Whenever the two stages disagree at a sampling instant, an 8-bit counter advances by one. The counter drives a bank of LEDs directly. A clean switch action therefore adds one count, and every bounce glitch adds more. Nothing is filtered: the aim is to expose the bounce, not to remove it.

The sampling instants come from a power-of-two prescaler selected by the parameter `PRESCALE_EXP`, gated by an external enable strobe. An exponent of zero samples on every enabled clock and shows every edge the clock can resolve. Larger exponents stretch the sampling period so that the behaviour can be compared against a debounce-style sampling rate. The reset input is asynchronous and active low. Its release is synchronised inside the block.

Top module: `bounce_edge_counter`

## Requirements
- R1: While `rst_ni` is low, `led_o` reads 0 without waiting for a clock edge. After `rst_ni` rises, the block stays in reset for two more rising clock edges.
- R2: A sampling instant occurs on every 2^`PRESCALE_EXP`-th rising edge at which `smp_en_i` is high. Only enabled edges advance the prescaler phase, and reset restarts that phase. With `PRESCALE_EXP` = 0, every enabled edge is a sampling instant.
- R3: At each sampling instant, the newer stage loads `sw_raw_i` and the older stage loads the previous content of the newer stage.
- R4: At a sampling instant where the two stages (values before the edge) differ, `led_o` shows the count plus one right after that edge.
- R5: At a sampling instant where both stages hold the same value, the count does not change.
- R6: On clock edges that are not sampling instants, including all edges with `smp_en_i` low, the count and both stages hold their values, whatever `sw_raw_i` does.
- R7: The count is `CNT_W` = 8 bits wide and wraps from 255 to 0 without saturating.
- R8: Rising and falling transitions count alike. A high pulse lasting one sampling period adds exactly two counts.
- R9: Both stages reset to 0. If `sw_raw_i` is already high and stays high from the first sampling instant after reset, exactly one count results, visible after the second sampling instant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_raw_i | input | 1 | Raw, unsynchronised switch level |
| smp_en_i | input | 1 | Enable strobe; prescaler phase and sampling advance only while high |
| led_o | output | CNT_W | Transition count, drives the LED bank |

## Verification
On every cycle the assertions check four things: the count only ever stays or steps by exactly one; it holds between sampling instants and whenever the two stages agree; a sampling instant never happens without the enable; and the internal reset keeps the count at zero. Other behaviours can only be shown by the bench's scenarios, scored against a reference model built from the requirements. These are the prescaler phase for a non-zero exponent, the exact edge at which a count appears, the wrap past 255, the two-count result of a single pulse, and the single count for an input already high after reset.

// File: rtl/bec_pkg.sv
package bec_pkg;

  // Number of sampling stages; the comparison uses exactly two.
  localparam int unsigned SMP_STAGES = 2;

  // Two-stage sample pair, newest first.
  typedef struct packed {
    logic newer;
    logic older;
  } smp_pair_t;

endpackage

// File: rtl/bec_reset_sync.sv
module bec_reset_sync #(
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [SYNC_LEN-1:0] chain_q;
  logic [SYNC_LEN-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[SYNC_LEN-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[SYNC_LEN-1];

endmodule

// File: rtl/bec_prescaler.sv
module bec_prescaler #(
  parameter int unsigned PRESCALE_EXP = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);

  generate
    if (PRESCALE_EXP == 0) begin : g_direct
      assign tick_o = en_i;
    end else begin : g_divide
      logic [PRESCALE_EXP-1:0] phase_q;
      logic [PRESCALE_EXP-1:0] phase_d;

      always_comb begin
        phase_d = phase_q;
        if (en_i) phase_d = phase_q + 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) phase_q <= '0;
        else         phase_q <= phase_d;
      end

      assign tick_o = en_i & (&phase_q);
    end
  endgenerate

endmodule

// File: rtl/bec_sampler.sv
module bec_sampler
  import bec_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      din_i,
  output smp_pair_t pair_o
);

  smp_pair_t pair_q;
  smp_pair_t pair_d;

  always_comb begin
    pair_d = pair_q;
    if (tick_i) begin
      pair_d.newer = din_i;
      pair_d.older = pair_q.newer;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pair_q <= '0;
    else         pair_q <= pair_d;
  end

  assign pair_o = pair_q;

  // R6: stages frozen between sampling instants
  a_r6_stage_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(pair_q));

endmodule

// File: rtl/bec_counter.sv
module bec_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R4 / R7: the count holds or steps by exactly one, modulo 2^CNT_W
  a_r4_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)));

endmodule

// File: rtl/bounce_edge_counter.sv
module bounce_edge_counter
  import bec_pkg::*;
#(
  parameter int unsigned PRESCALE_EXP = 0,
  parameter int unsigned CNT_W        = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_raw_i,
  input  logic             smp_en_i,
  output logic [CNT_W-1:0] led_o
);

  logic      rst_n_sync;
  logic      smp_tick;
  smp_pair_t pair;
  logic      differ;
  logic      count_inc;

  bec_reset_sync #(.SYNC_LEN(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_sync)
  );

  bec_prescaler #(.PRESCALE_EXP(PRESCALE_EXP)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .en_i   (smp_en_i),
    .tick_o (smp_tick)
  );

  bec_sampler u_smp (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .tick_i (smp_tick),
    .din_i  (sw_raw_i),
    .pair_o (pair)
  );

  assign differ    = pair.newer ^ pair.older;
  assign count_inc = smp_tick & differ;

  bec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .inc_i  (count_inc),
    .cnt_o  (led_o)
  );

  // R2: no sampling instant without the enable strobe
  a_r2_tick_needs_en: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    smp_tick |-> smp_en_i);

  // R5: equal stages at a sampling instant leave the count alone
  a_r5_equal_no_count: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (smp_tick && (pair.newer == pair.older)) |=> $stable(led_o));

  // R6: the count holds between sampling instants
  a_r6_count_hold: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    !smp_tick |=> $stable(led_o));

  // R1: internal reset keeps the count cleared
  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_n_sync |-> (led_o == '0));

endmodule

// File: tb/bounce_edge_counter_test.sv
module bounce_edge_counter_test;

  localparam int unsigned EXP_A = 0;
  localparam int unsigned EXP_B = 2;

  logic       clk;
  logic       rst_n;
  logic       sw;
  logic       en;
  logic [7:0] led_a;
  logic [7:0] led_b;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  string cur_req = "R4";

  // reference model state, one slot per instance
  int  m_ph  [2];
  int  m_new [2];
  int  m_old [2];
  int  m_cnt [2];
  bit  model_on = 0;

  bounce_edge_counter #(.PRESCALE_EXP(EXP_A), .CNT_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sw_raw_i(sw), .smp_en_i(en), .led_o(led_a));

  bounce_edge_counter #(.PRESCALE_EXP(EXP_B), .CNT_W(8)) uut_div (
    .clk_i(clk), .rst_ni(rst_n), .sw_raw_i(sw), .smp_en_i(en), .led_o(led_b));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int exp_of(input int i);
    return (i == 0) ? EXP_A : EXP_B;
  endfunction

  function automatic int wrap8(input int v);
    return v & 255;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 2; i++) begin
      m_ph[i] = 0; m_new[i] = 0; m_old[i] = 0; m_cnt[i] = 0;
    end
  endtask

  task automatic model_edge();
    for (int i = 0; i < 2; i++) begin
      bit tick;
      int per;
      per  = 1 << exp_of(i);
      tick = 0;
      if (model_on && en) begin
        tick    = (m_ph[i] == per - 1);
        m_ph[i] = (m_ph[i] + 1) % per;
      end
      if (tick) begin
        if (m_new[i] != m_old[i]) m_cnt[i] = wrap8(m_cnt[i] + 1);
        m_old[i] = m_new[i];
        m_new[i] = int'(sw);
      end
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: model updates on the edge, outputs compared at the falling edge
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (model_on) begin
      check(cur_req, int'(led_a), m_cnt[0]);
      check(cur_req, int'(led_b), m_cnt[1]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_on = 0;
    model_clear();
    #1;
    check("R1", int'(led_a), 0);
    check("R1", int'(led_b), 0);
    en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // two synchronising edges plus margin, enable low so nothing moves
    repeat (4) @(negedge clk);
    check("R1", int'(led_a), 0);
    check("R1", int'(led_b), 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int snap_a;
    int snap_b;
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    sw    = 1'b0;
    en    = 1'b0;
    model_clear();
    repeat (4) @(negedge clk);
    check("R1", int'(led_a), 0);
    check("R1", int'(led_b), 0);

    // R9: input high before the first sampling instant
    sw = 1'b1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1;
    en = 1'b1;
    cur_req = "R9";
    repeat (12) step();
    check("R9", int'(led_a), 1);
    check("R9", int'(led_b), 1);

    // R8: a single-period low pulse on the undivided instance adds two
    cur_req = "R8";
    snap_a = int'(led_a);
    sw = 1'b0; step();
    sw = 1'b1;
    repeat (4) step();
    check("R8", int'(led_a), wrap8(snap_a + 2));

    // R5: steady input, no change
    cur_req = "R5";
    repeat (10) step();
    snap_a = int'(led_a); snap_b = int'(led_b);
    repeat (20) step();
    check("R5", int'(led_a), snap_a);
    check("R5", int'(led_b), snap_b);

    // R6: enable low, input wiggles, nothing moves
    cur_req = "R6";
    en = 1'b0;
    snap_a = int'(led_a); snap_b = int'(led_b);
    for (int k = 0; k < 25; k++) begin
      sw = ~sw;
      step();
    end
    check("R6", int'(led_a), snap_a);
    check("R6", int'(led_b), snap_b);

    // R3/R4: after re-enabling, the stale stages are compared first
    cur_req = "R3";
    en = 1'b1;
    repeat (12) step();

    // R7: toggle every clock to wrap the counter several times
    cur_req = "R7";
    for (int k = 0; k < 700; k++) begin
      sw = ~sw;
      step();
    end

    // R2: divided instance, enable strobing irregularly
    cur_req = "R2";
    for (int k = 0; k < 400; k++) begin
      en = ((k % 3) != 1);
      if ((k % 5) == 0) sw = ~sw;
      step();
    end

    // R4: random bounce-like stimulus
    cur_req = "R4";
    for (int k = 0; k < 3000; k++) begin
      if (($urandom % 4) == 0) sw = ~sw;
      en = (($urandom % 4) != 0);
      step();
    end

    // R1: reset in the middle of activity
    do_reset();
    model_on = 1;
    en = 1'b1;
    sw = 1'b0;
    cur_req = "R4";
    for (int k = 0; k < 200; k++) begin
      if (($urandom % 3) == 0) sw = ~sw;
      step();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule